// File: doc/BRIEF.md
# Four-Level Address Strap Decoder

This block works out how each of two address strap pins is wired. Each pin can be tied to ground, to the supply, to the bus clock line or to the bus data line. The block watches each pin against SCL and SDA for the whole of every bus transmission, from START to STOP. It looks only at the bus conditions and not at the address byte, so transmissions aimed at other devices refresh the decode just as well. When the STOP arrives, each pin is settled into one of its four classes. The two classes together give four slave address bits.

Until the first transmission has been decoded, a pin's class follows its sensed level. A pin tied to a bus line therefore reads as supply-tied while the bus idles high. The block also captures the port defaults once, while the power-on reset is held. These are the default level of eight open-drain ports, their pullup enables and the default level of eight push-pull outputs. Each of the two pins governs its own group of four. Later decodes never rewrite these defaults.

Top module: `addr_strap_decoder`

## Requirements
- R1: Before any transmission has been decoded since reset, each pin's class is taken from its present level: high reads as supply, low reads as ground.
- R2: The first strap pin drives addr_lo (A1:A0) as follows: ground 00, supply 01, clock 10, data 11.
- R3: The second strap pin drives addr_hi (A3:A2) as follows: clock 00, data 01, ground 10, supply 11.
- R4: A pin whose level equals SCL in every cycle from START to STOP, and which does not stay constant, is classed as clock-tied.
- R5: A pin whose level equals SDA in every cycle from START to STOP is classed as data-tied. This includes the START cycle, where SDA is low while SCL is high.
- R6: A pin that holds one level through the whole transmission is classed by that level: ground if low, supply if high. This check takes priority over R4 and R5.
- R7: A class changes only in the cycle after a STOP that ends a tracked transmission. Between transmissions it holds even if the pin level changes.
- R8: Every transmission on the bus is decoded again, whatever bytes it carries.
- R9: While reset is held, io_dflt, pull_en and out_dflt take bit i from the first pin's level for i below 4, and from the second pin's level for the upper four bits.
- R10: After reset is released, io_dflt, pull_en and out_dflt never change, whatever later decodes produce.
- R11: A pin that matches neither bus line and is not constant keeps its previous class.
- R12: A START that is not followed by a STOP commits nothing. A later START restarts the tracking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| scl | input | 1 | Synchronized bus clock level |
| sda | input | 1 | Synchronized bus data level |
| strap_a | input | 1 | Sensed level of the first strap pin |
| strap_b | input | 1 | Sensed level of the second strap pin |
| addr_lo | output | 2 | Address bits A1:A0 from the first pin |
| addr_hi | output | 2 | Address bits A3:A2 from the second pin |
| io_dflt | output | 2*GROUP | Open-drain port default levels |
| pull_en | output | 2*GROUP | Pullup enables of the open-drain ports |
| out_dflt | output | 2*GROUP | Push-pull output default levels |

## Verification
The assertions check several properties on every cycle. The defaults stay frozen after reset and each default group is uniform. The address bits stay in the supply or ground codes until the first decode. A decoded address changes only right after a tracked STOP, and such a STOP always commits and ends the tracking. The classification itself can only be shown by the bench's scenarios. These cover which class each wiring yields, the priority of constant levels, a pin that matches nothing, and an unfinished transmission followed by a restart. In each scenario the outputs are compared against the bench's own model.

// File: rtl/addr_strap_decoder.sv
module addr_strap_decoder #(
  parameter int GROUP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl,
  input  logic               sda,
  input  logic               strap_a,
  input  logic               strap_b,
  output logic [1:0]         addr_lo,
  output logic [1:0]         addr_hi,
  output logic [2*GROUP-1:0] io_dflt,
  output logic [2*GROUP-1:0] pull_en,
  output logic [2*GROUP-1:0] out_dflt
);
  localparam logic [1:0] TIE_GND = 2'd0;
  localparam logic [1:0] TIE_VCC = 2'd1;
  localparam logic [1:0] TIE_SCL = 2'd2;
  localparam logic [1:0] TIE_SDA = 2'd3;

  logic scl_q, sda_q, busy, decoded;
  logic [2*GROUP-1:0] dflt;
  logic [1:0] pin;
  logic [1:0] eff [2];

  wire start = scl & scl_q & sda_q & ~sda;
  wire stop  = scl & scl_q & ~sda_q & sda;

  assign pin = {strap_b, strap_a};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      busy    <= 1'b0;
      decoded <= 1'b0;
      dflt    <= {{GROUP{strap_b}}, {GROUP{strap_a}}};
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start) busy <= 1'b1;
      else if (stop && busy) begin
        busy    <= 1'b0;
        decoded <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_pin
    logic ms, md, st, lvl;
    logic ms_n, md_n, st_n;
    logic [1:0] cls, nxt;

    assign ms_n = ms & (pin[g] == scl);
    assign md_n = md & (pin[g] == sda);
    assign st_n = st & (pin[g] == lvl);

    always_comb begin
      if (st_n)      nxt = lvl ? TIE_VCC : TIE_GND;
      else if (ms_n) nxt = TIE_SCL;
      else if (md_n) nxt = TIE_SDA;
      else           nxt = cls;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ms  <= 1'b0;
        md  <= 1'b0;
        st  <= 1'b0;
        lvl <= 1'b0;
        cls <= TIE_GND;
      end else if (start) begin
        ms  <= pin[g] == scl;
        md  <= pin[g] == sda;
        st  <= 1'b1;
        lvl <= pin[g];
      end else if (busy) begin
        ms <= ms_n;
        md <= md_n;
        st <= st_n;
        if (stop) cls <= nxt;
      end
    end

    assign eff[g] = decoded ? cls : (pin[g] ? TIE_VCC : TIE_GND);
  end

  assign addr_lo  = eff[0];
  assign addr_hi  = eff[1] ^ 2'b10;
  assign io_dflt  = dflt;
  assign pull_en  = dflt;
  assign out_dflt = dflt;
endmodule

module addr_strap_decoder_chk #(
  parameter int GROUP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl,
  input logic               sda,
  input logic               scl_q,
  input logic               sda_q,
  input logic               busy,
  input logic               decoded,
  input logic [1:0]         addr_lo,
  input logic [1:0]         addr_hi,
  input logic [2*GROUP-1:0] io_dflt,
  input logic [2*GROUP-1:0] pull_en
);
  // R10
  dflt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(io_dflt) && $stable(pull_en));

  // R9
  pull_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pull_en[GROUP-1:0]) == 0 || $countones(pull_en[GROUP-1:0]) == GROUP) &&
    ($countones(pull_en[2*GROUP-1:GROUP]) == 0 || $countones(pull_en[2*GROUP-1:GROUP]) == GROUP));

  // R1
  predecode_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !decoded |-> !addr_lo[1] && addr_hi[1]);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decoded && $past(decoded) && !$past(busy) |-> $stable({addr_hi, addr_lo}));

  // R7
  stop_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && scl && scl_q && !sda_q && sda |=> decoded && !busy);
endmodule

bind addr_strap_decoder addr_strap_decoder_chk #(.GROUP(GROUP)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .scl_q(scl_q), .sda_q(sda_q),
  .busy(busy), .decoded(decoded), .addr_lo(addr_lo), .addr_hi(addr_hi),
  .io_dflt(io_dflt), .pull_en(pull_en)
);

// File: tb/addr_strap_decoder_test.sv
module addr_strap_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, strap_a = 1'b0, strap_b = 1'b0;
  logic [1:0] addr_lo, addr_hi;
  logic [2*G-1:0] io_dflt, pull_en, out_dflt;

  int compared = 0, mismatched = 0, cycles = 0;
  int mode_a = 0, mode_b = 0;

  logic m_prev_scl = 1'b1, m_prev_sda = 1'b1, m_busy = 1'b0, m_dec = 1'b0;
  logic [1:0] m_cls [2];
  logic [2*G-1:0] m_dflt = '0;
  logic [3:0] hist [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_strap_decoder #(.GROUP(G)) uut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .strap_a(strap_a), .strap_b(strap_b),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .io_dflt(io_dflt), .pull_en(pull_en), .out_dflt(out_dflt)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // wiring: 0 ground, 1 supply, 2 clock line, 3 data line, 4 inverted clock (matches nothing)
  function automatic logic pinval(int mode, logic s, logic d);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return s;
      3: return d;
      default: return ~s;
    endcase
  endfunction

  function automatic logic [1:0] classify(int g, logic [1:0] old);
    bit st = 1, ms = 1, md = 1;
    logic p0 = hist[0][g];
    foreach (hist[i]) begin
      if (hist[i][g] != p0) st = 0;
      if (hist[i][g] != hist[i][2]) ms = 0;
      if (hist[i][g] != hist[i][3]) md = 0;
    end
    if (st) return {1'b0, p0};
    if (ms) return 2'd2;
    if (md) return 2'd3;
    return old;
  endfunction

  function automatic logic [1:0] eff(int g);
    logic p = (g == 0) ? strap_a : strap_b;
    return m_dec ? m_cls[g] : {1'b0, p};
  endfunction

  task automatic model_update();
    logic is_start, is_stop;
    if (!rst_n) begin
      m_prev_scl = 1'b1; m_prev_sda = 1'b1; m_busy = 1'b0; m_dec = 1'b0;
      m_cls[0] = 2'd0; m_cls[1] = 2'd0;
      m_dflt = {{G{strap_b}}, {G{strap_a}}};
      hist.delete();
      return;
    end
    is_start = m_prev_scl && scl && m_prev_sda && !sda;
    is_stop  = m_prev_scl && scl && !m_prev_sda && sda;
    if (is_start) begin
      hist.delete();
      hist.push_back({sda, scl, strap_b, strap_a});
      m_busy = 1'b1;
    end else if (m_busy) begin
      hist.push_back({sda, scl, strap_b, strap_a});
      if (is_stop) begin
        m_cls[0] = classify(0, m_cls[0]);
        m_cls[1] = classify(1, m_cls[1]);
        m_dec = 1'b1;
        m_busy = 1'b0;
      end
    end
    m_prev_scl = scl;
    m_prev_sda = sda;
  endtask

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(logic s, logic d, string tag);
    @(negedge clk);
    scl = s; sda = d;
    strap_a = pinval(mode_a, s, d);
    strap_b = pinval(mode_b, s, d);
    @(posedge clk);
    #1;
    model_update();
    check(tag, "addr_lo", {6'd0, addr_lo}, {6'd0, eff(0)});
    check(tag, "addr_hi", {6'd0, addr_hi}, {6'd0, eff(1) ^ 2'b10});
    check(tag, "io_dflt", io_dflt, m_dflt);
    check(tag, "pull_en", pull_en, m_dflt);
    check(tag, "out_dflt", out_dflt, m_dflt);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, tag);
  endtask

  task automatic xfer(logic [7:0] b, bit with_stop, string tag);
    step(1'b1, 1'b1, tag);
    step(1'b1, 1'b0, tag);
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, b[i], tag);
      step(1'b1, b[i], tag);
      step(1'b0, b[i], tag);
    end
    step(1'b0, 1'b0, tag);
    step(1'b1, 1'b0, tag);
    step(1'b0, 1'b0, tag);
    if (with_stop) begin
      step(1'b1, 1'b0, tag);
      step(1'b1, 1'b1, tag);
    end
  endtask

  task automatic do_reset(int a, int b, string tag);
    mode_a = a; mode_b = b;
    rst_n = 1'b0;
    idle(3, tag);
    rst_n = 1'b1;
  endtask

  initial begin
    // R9: ground / supply wiring sets low group 0, high group 1
    do_reset(0, 1, "R9");
    idle(3, "R1");
    // R9: bus-tied pins look high at reset; R1 reads them as supply
    do_reset(2, 3, "R9");
    idle(3, "R1");
    // R4 and R5: clock-tied first pin, data-tied second pin
    xfer(8'hA5, 1, "R4");
    idle(3, "R5");
    idle(2, "R10");
    // R7: rewiring without a transmission changes nothing
    mode_a = 3; mode_b = 2;
    idle(4, "R7");
    // R8: another transmission, unrelated address byte, re-decodes
    xfer(8'h3C, 1, "R8");
    idle(3, "R2");
    idle(2, "R3");
    // R6: constant pins classed by level
    mode_a = 1; mode_b = 0;
    xfer(8'hFF, 1, "R7");
    idle(3, "R6");
    mode_a = 0; mode_b = 1;
    xfer(8'h00, 1, "R6");
    idle(3, "R2");
    idle(3, "R10");
    // R12: unfinished transmission commits nothing, restart then commits
    mode_a = 2; mode_b = 3;
    xfer(8'h5A, 0, "R12");
    idle(3, "R12");
    xfer(8'h81, 1, "R12");
    idle(3, "R3");
    // R11: first pin matches neither bus line
    mode_a = 4; mode_b = 1;
    xfer(8'hC3, 1, "R11");
    idle(3, "R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule